// File: doc/BRIEF.md
# Queued Conversion Command Sequencer

This block stores a 64-entry table of conversion commands and walks it for two independent queues. Each command selects an analog channel and a sample-time code, and it can also ask its queue to halt once the command has finished. Queue 1 always starts at entry 0. Queue 2 starts at an entry given by the `q2_begin` input. The sequencer sends one request at a time to an external converter and waits for its done strobe. On that same cycle it raises a result-write strobe that carries the entry index and the queue it belongs to.

Software fills the table and reads back three pointers through a small register window. The first is the entry most recently fetched. The other two are the last entry each queue actually converted. A stop-mode input clears all sequencing state and sets every pointer to 63. A debug-mode input holds off new fetches and leaves the pointers untouched.

Top module: `qconv_seq`

## Requirements
- R1: A register write to addresses 0 to 63 stores `reg_wdata[9:0]` in that table entry. A read of the same address returns the entry with bits 15:10 read as zero. The entry layout is: bit 9 = pause, bits 8:6 = sample-time code, bits 5:0 = channel.
- R2: The register window reads address 64 as the current pointer, 65 as the queue 1 last pointer and 66 as the queue 2 last pointer. Writes to addresses 64 and above change nothing. After reset all three pointers read 63.
- R3: A queue 1 trigger starts at entry 0 and requests the entries in ascending order, each with the entry's channel and sample code. An entry whose channel is 63 ends the queue without a request, and the current pointer stays on that entry.
- R4: When queue 1 fetches the entry at `q2_begin`, queue 1 ends with no request. The current pointer then equals `q2_begin`, and the queue 1 last pointer keeps the last entry that queue 1 converted.
- R5: Each last pointer takes its new value on the clock edge where a result of its own queue is written (`res_we` with `res_queue` 0 for queue 1, 1 for queue 2). At no other time does it change, whichever queue is running.
- R6: While `stop_mode` is high, the request drops on the next cycle, both queues are cleared, triggers are ignored and all three pointers read 63.
- R7: While `debug_mode` is high, no new entry is fetched and the pointers keep their values. A trigger taken during debug starts its queue once debug clears.
- R8: Only one conversion is outstanding at a time. `conv_req` stays high with stable channel and sample code until `conv_done` arrives. `res_we` is asserted in the `conv_done` cycle with `res_idx` equal to the entry.
- R9: After an entry with its pause bit set completes, its queue halts. The queue's next trigger resumes from the following entry.
- R10: Queue 1 has priority. A queue 1 trigger during a queue 2 conversion lets that conversion finish, then runs queue 1. Queue 2 afterwards resumes from its next entry.
- R11: A queue 2 trigger on an idle queue 2 starts at `q2_begin`. Queue 2 ends after converting entry 63, or on an entry with channel 63.
- R12: Sequencing never alters table contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_mode | input | 1 | Level: clears sequencing, pointers to 63 |
| debug_mode | input | 1 | Level: holds off new fetches |
| trig_q1 | input | 1 | One-cycle queue 1 trigger |
| trig_q2 | input | 1 | One-cycle queue 2 trigger |
| q2_begin | input | 6 | First entry of queue 2 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| conv_req | output | 1 | Conversion request |
| conv_chan | output | 6 | Requested channel |
| conv_samp | output | 3 | Requested sample-time code |
| conv_done | input | 1 | One-cycle converter completion strobe |
| res_we | output | 1 | Result write strobe |
| res_queue | output | 1 | Queue of the result (0 = queue 1, 1 = queue 2) |
| res_idx | output | 6 | Table entry of the result |

## Verification
The assertions rely on the converter pulsing `conv_done` for exactly one cycle, and only while `conv_req` is high. They also rely on triggers being single-cycle pulses and on `q2_begin` staying steady while a queue runs. The bench's converter model answers each request a fixed number of cycles after it rises and then deasserts done. Triggers, mode levels and `q2_begin` are changed only on falling edges and only between runs. The one exception is the priority scenario, which pulses a queue 1 trigger during a queue 2 conversion on purpose.

// File: rtl/qconv_pkg.sv
package qconv_pkg;
    localparam int unsigned CHW = 6;
    localparam int unsigned STW = 3;
    localparam int unsigned EW  = CHW + STW + 1;
    localparam int unsigned DW  = 16;

    typedef struct packed {
        logic           pause;
        logic [STW-1:0] samp;
        logic [CHW-1:0] chan;
    } cmd_t;

    typedef enum logic {E_IDLE, E_CONV} eng_t;

    function automatic logic is_eoq(cmd_t c);
        return &c.chan;
    endfunction
endpackage

// File: rtl/qconv_table.sv
module qconv_table
    import qconv_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  cmd_t          wdata,
    input  logic [AW-1:0] raddr_a,
    output cmd_t          rdata_a,
    input  logic [AW-1:0] raddr_b,
    output cmd_t          rdata_b
);
    cmd_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/qconv_lastptr.sv
module qconv_lastptr #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stop,
    input  logic          upd,
    input  logic [AW-1:0] idx,
    output logic [AW-1:0] last
);
    always_ff @(posedge clk) begin
        if (rst || stop) last <= '1;
        else if (upd)    last <= idx;
    end

    // R6: stop mode forces the pointer to the top entry
    assert_stop_top_R6: assert property (@(posedge clk) disable iff (rst)
        stop |=> (last == '1));
endmodule

// File: rtl/qconv_engine.sv
module qconv_engine
    import qconv_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           stop,
    input  logic           dbg,
    input  logic           trig_q1,
    input  logic           trig_q2,
    input  logic [AW-1:0]  q2_begin,
    output logic [AW-1:0]  ent_idx,
    input  cmd_t           ent,
    output logic           conv_req,
    output logic [CHW-1:0] conv_chan,
    output logic [STW-1:0] conv_samp,
    input  logic           conv_done,
    output logic           res_we,
    output logic           res_queue,
    output logic [AW-1:0]  res_idx,
    output logic [AW-1:0]  cwp
);
    eng_t          eng;
    logic [1:0]    run, paused, trig;
    logic [AW-1:0] nxt [2];
    logic [AW-1:0] start_ptr [2];
    logic          cur, fq, fetch_go, hit_b, end_fetch, last_ent;
    cmd_t          lat;

    assign trig         = {trig_q2, trig_q1};
    assign start_ptr[0] = '0;
    assign start_ptr[1] = q2_begin;
    assign fq           = ~run[0];
    assign ent_idx      = nxt[fq];
    assign fetch_go     = (eng == E_IDLE) && !dbg && (|run);
    assign hit_b        = !fq && (nxt[0] == q2_begin);
    assign end_fetch    = is_eoq(ent) || hit_b;
    assign last_ent     = (cwp == AW'(DEPTH - 1));

    always_ff @(posedge clk) begin
        if (rst || stop) begin
            eng    <= E_IDLE;
            run    <= '0;
            paused <= '0;
            nxt[0] <= '0;
            nxt[1] <= '0;
            cwp    <= '1;
            cur    <= 1'b0;
            lat    <= '0;
        end else begin
            for (int q = 0; q < 2; q++) begin
                if (trig[q] && !run[q]) begin
                    run[q]    <= 1'b1;
                    paused[q] <= 1'b0;
                    if (!paused[q]) nxt[q] <= start_ptr[q];
                end
            end
            if (fetch_go) begin
                cwp <= ent_idx;
                cur <= fq;
                if (end_fetch) run[fq] <= 1'b0;
                else begin
                    eng <= E_CONV;
                    lat <= ent;
                end
            end
            if (eng == E_CONV && conv_done) begin
                eng      <= E_IDLE;
                nxt[cur] <= cwp + 1'b1;
                if (last_ent) run[cur] <= 1'b0;
                else if (lat.pause) begin
                    run[cur]    <= 1'b0;
                    paused[cur] <= 1'b1;
                end
            end
        end
    end

    assign conv_req  = (eng == E_CONV);
    assign conv_chan = lat.chan;
    assign conv_samp = lat.samp;
    assign res_we    = (eng == E_CONV) && conv_done;
    assign res_queue = cur;
    assign res_idx   = cwp;

    assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (conv_req && !conv_done && !stop) |=> (conv_req && $stable(conv_chan) && $stable(conv_samp)));

    assert_stop_drop_R6: assert property (@(posedge clk) disable iff (rst)
        stop |=> !conv_req);

    assert_dbg_nofetch_R7: assert property (@(posedge clk) disable iff (rst)
        (dbg && !conv_req) |=> !conv_req);

    assert_no_eoq_req_R3: assert property (@(posedge clk) disable iff (rst)
        conv_req |-> (conv_chan != '1));
endmodule

// File: rtl/qconv_seq.sv
module qconv_seq
    import qconv_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           stop_mode,
    input  logic           debug_mode,
    input  logic           trig_q1,
    input  logic           trig_q2,
    input  logic [AW-1:0]  q2_begin,
    input  logic           reg_we,
    input  logic [AW:0]    reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    output logic           conv_req,
    output logic [CHW-1:0] conv_chan,
    output logic [STW-1:0] conv_samp,
    input  logic           conv_done,
    output logic           res_we,
    output logic           res_queue,
    output logic [AW-1:0]  res_idx
);
    cmd_t          ent, reg_ent;
    logic [AW-1:0] ent_idx, cwp;
    logic [AW-1:0] last_ptr [2];
    logic          tbl_we;

    assign tbl_we = reg_we && !reg_addr[AW];

    qconv_table #(.DEPTH(DEPTH)) u_tbl (
        .clk     (clk),
        .we      (tbl_we),
        .waddr   (reg_addr[AW-1:0]),
        .wdata   (reg_wdata[EW-1:0]),
        .raddr_a (ent_idx),
        .rdata_a (ent),
        .raddr_b (reg_addr[AW-1:0]),
        .rdata_b (reg_ent)
    );

    qconv_engine #(.DEPTH(DEPTH)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .stop      (stop_mode),
        .dbg       (debug_mode),
        .trig_q1   (trig_q1),
        .trig_q2   (trig_q2),
        .q2_begin  (q2_begin),
        .ent_idx   (ent_idx),
        .ent       (ent),
        .conv_req  (conv_req),
        .conv_chan (conv_chan),
        .conv_samp (conv_samp),
        .conv_done (conv_done),
        .res_we    (res_we),
        .res_queue (res_queue),
        .res_idx   (res_idx),
        .cwp       (cwp)
    );

    for (genvar q = 0; q < 2; q++) begin : g_last
        qconv_lastptr #(.AW(AW)) u_lp (
            .clk  (clk),
            .rst  (rst),
            .stop (stop_mode),
            .upd  (res_we && (res_queue == 1'(q))),
            .idx  (res_idx),
            .last (last_ptr[q])
        );
    end

    always_comb begin
        reg_rdata = '0;
        if (!reg_addr[AW]) reg_rdata = DW'(reg_ent);
        else begin
            case (reg_addr[AW-1:0])
                AW'(0):  reg_rdata = DW'(cwp);
                AW'(1):  reg_rdata = DW'(last_ptr[0]);
                AW'(2):  reg_rdata = DW'(last_ptr[1]);
                default: reg_rdata = '0;
            endcase
        end
    end

    assert_q2_upd_R5: assert property (@(posedge clk) disable iff (rst)
        (res_we && res_queue && !stop_mode) |=> (last_ptr[1] == $past(res_idx)));

    assert_q2_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!(res_we && res_queue) && !stop_mode) |=> $stable(last_ptr[1]));

    assert_q1_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!(res_we && !res_queue) && !stop_mode) |=> $stable(last_ptr[0]));
endmodule

// File: tb/sim_qconv_seq.sv
`timescale 1ns/1ps
module sim_qconv_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stop_mode = 1'b0, debug_mode = 1'b0;
    logic        trig_q1 = 1'b0, trig_q2 = 1'b0;
    logic [5:0]  q2_begin = 6'd8;
    logic        reg_we = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        conv_req;
    logic [5:0]  conv_chan;
    logic [2:0]  conv_samp;
    logic        conv_done = 1'b0;
    logic        res_we, res_queue;
    logic [5:0]  res_idx;

    int n_chk = 0, n_fail = 0;
    int log_n = 0, dcnt = 0;
    logic [5:0] log_chan [0:255];
    logic [2:0] log_samp [0:255];
    logic [5:0] log_idx  [0:255];

    always #2 clk = ~clk;

    qconv_seq u0 (
        .clk(clk), .rst(rst), .stop_mode(stop_mode), .debug_mode(debug_mode),
        .trig_q1(trig_q1), .trig_q2(trig_q2), .q2_begin(q2_begin),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .conv_req(conv_req), .conv_chan(conv_chan), .conv_samp(conv_samp), .conv_done(conv_done),
        .res_we(res_we), .res_queue(res_queue), .res_idx(res_idx)
    );

    // converter model: done 3 cycles after a request is seen, for one cycle
    always @(negedge clk) begin
        if (conv_done) conv_done <= 1'b0;
        else if (conv_req) begin
            if (dcnt == 3) begin
                conv_done <= 1'b1;
                log_chan[log_n[7:0]] <= conv_chan;
                log_samp[log_n[7:0]] <= conv_samp;
                log_idx[log_n[7:0]]  <= res_idx;
                log_n <= log_n + 1;
                dcnt <= 0;
            end else dcnt <= dcnt + 1;
        end else dcnt <= 0;
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = 7'(a); reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        reg_addr = 7'(a);
        #0.5;
        v = int'(reg_rdata);
    endtask

    task automatic pulse1();
        @(negedge clk); trig_q1 = 1'b1;
        @(negedge clk); trig_q1 = 1'b0;
    endtask

    task automatic pulse2();
        @(negedge clk); trig_q2 = 1'b1;
        @(negedge clk); trig_q2 = 1'b0;
    endtask

    task automatic wait_quiet();
        int q = 0;
        for (int i = 0; i < 3000 && q < 10; i++) begin
            @(negedge clk);
            if (conv_req) q = 0; else q++;
        end
    endtask

    task automatic chk_ptrs(input string tag, input int c, input int l1, input int l2);
        int v;
        rd(64, v); chk(v == c,  {tag, " current"}, v, c);
        rd(65, v); chk(v == l1, {tag, " q1 last"}, v, l1);
        rd(66, v); chk(v == l2, {tag, " q2 last"}, v, l2);
    endtask

    function automatic logic [15:0] mk(input logic p, input int s, input int c);
        return {6'd0, p, 3'(s), 6'(c)};
    endfunction

    task automatic chk_log(input string tag, input int base, input int exp[$]);
        chk(log_n - base == exp.size(), {tag, " result count"}, log_n - base, exp.size());
        foreach (exp[i])
            chk(int'(log_chan[8'(base + i)]) == exp[i], {tag, " channel order"},
                int'(log_chan[8'(base + i)]), exp[i]);
    endtask

    task automatic t_reset();
        chk(conv_req == 1'b0, "R2 no request after reset", int'(conv_req), 0);
        chk_ptrs("R2 reset", 63, 63, 63);
    endtask

    task automatic t_table();
        int v;
        wr(0, mk(0, 1, 3)); wr(1, mk(0, 2, 5)); wr(2, mk(0, 0, 7));
        for (int i = 3; i < 8; i++) wr(i, mk(0, i - 3, 7 + i));
        wr(8, mk(0, 4, 20)); wr(9, mk(1, 5, 21)); wr(10, mk(0, 6, 22)); wr(11, mk(0, 0, 63));
        rd(1, v);  chk(v == 16'h0085, "R1 entry readback", v, 16'h0085);
        rd(9, v);  chk(v == 16'h0355, "R1 pause and sample fields", v, 16'h0355);
        wr(20, 16'hFFFF);
        rd(20, v); chk(v == 16'h03FF, "R1 upper bits read zero", v, 16'h03FF);
        wr(65, 16'h0000); wr(64, 16'h0005);
        chk_ptrs("R2 writes ignored", 63, 63, 63);
    endtask

    task automatic t_q1_run();
        int b = log_n;
        pulse1(); wait_quiet();
        chk_log("R3 queue 1 sequence", b, '{3, 5, 7, 10, 11, 12, 13, 14});
        chk(log_samp[8'(b + 1)] == 3'd2, "R8 sample code", int'(log_samp[8'(b + 1)]), 2);
        chk(log_idx[8'(b + 7)] == 6'd7, "R8 result index", int'(log_idx[8'(b + 7)]), 7);
        chk_ptrs("R4 end at q2 begin", 8, 7, 63);
    endtask

    task automatic t_q2_pause();
        int b = log_n;
        pulse2(); wait_quiet();
        chk_log("R9 q2 until pause", b, '{20, 21});
        chk_ptrs("R9 paused", 9, 7, 9);
        b = log_n;
        pulse2(); wait_quiet();
        chk_log("R9 resume after pause", b, '{22});
        chk_ptrs("R11 end code q2", 11, 7, 10);
    endtask

    task automatic t_q2_top();
        int b = log_n;
        wr(62, mk(0, 1, 30)); wr(63, mk(0, 1, 31));
        @(negedge clk); q2_begin = 6'd62;
        pulse2(); wait_quiet();
        chk_log("R11 q2 from begin to 63", b, '{30, 31});
        chk_ptrs("R11 end after 63 R5 q1 kept", 63, 7, 63);
        @(negedge clk); q2_begin = 6'd8;
    endtask

    task automatic t_priority();
        int b = log_n;
        wr(9, mk(0, 5, 21));
        pulse2();
        for (int i = 0; i < 20 && !conv_req; i++) @(negedge clk);
        pulse1();
        wait_quiet();
        chk_log("R10 priority order", b, '{20, 3, 5, 7, 10, 11, 12, 13, 14, 21, 22});
        chk_ptrs("R10 final pointers", 11, 7, 10);
    endtask

    task automatic t_stop();
        int seen = 0;
        pulse1();
        for (int i = 0; i < 20 && !conv_req; i++) @(negedge clk);
        stop_mode = 1'b1;
        @(negedge clk);
        chk(conv_req == 1'b0, "R6 request dropped", int'(conv_req), 0);
        chk_ptrs("R6 stop pointers", 63, 63, 63);
        trig_q1 = 1'b1; @(negedge clk); trig_q1 = 1'b0;
        @(negedge clk); stop_mode = 1'b0;
        for (int i = 0; i < 12; i++) begin @(negedge clk); if (conv_req) seen++; end
        chk(seen == 0, "R6 trigger ignored in stop", seen, 0);
    endtask

    task automatic t_debug();
        int seen = 0, b = log_n;
        debug_mode = 1'b1;
        pulse1();
        for (int i = 0; i < 12; i++) begin @(negedge clk); if (conv_req) seen++; end
        chk(seen == 0, "R7 no fetch in debug", seen, 0);
        chk_ptrs("R7 pointers held", 63, 63, 63);
        debug_mode = 1'b0;
        wait_quiet();
        chk_log("R7 queue runs after debug", b, '{3, 5, 7, 10, 11, 12, 13, 14});
        chk_ptrs("R7 after run", 8, 7, 63);
    endtask

    task automatic t_eoq_q1();
        int v, b = log_n;
        wr(2, mk(0, 0, 63));
        pulse1(); wait_quiet();
        chk_log("R3 end code in q1", b, '{3, 5});
        chk_ptrs("R3 end code pointers", 2, 1, 63);
        rd(0, v); chk(v == int'(mk(0, 1, 3)), "R12 table unchanged", v, int'(mk(0, 1, 3)));
        rd(8, v); chk(v == int'(mk(0, 4, 20)), "R12 table unchanged", v, int'(mk(0, 4, 20)));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_table();
        t_q1_run();
        t_q2_pause();
        t_q2_top();
        t_priority();
        t_stop();
        t_debug();
        t_eoq_q1();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule